// File: doc/BRIEF.md
# Cascadable Synchronous Up/Down Counter

This block is a presettable binary counter, four bits wide by default. It counts up or down on the rising clock edge. All state bits change together on that edge and at no other time. Counting needs two active-low enables at once: a parallel enable and a trickle enable. An active-low synchronous load has priority over counting and copies the data inputs into the count.

A combinational active-low carry output goes low while the trickle enable is asserted and the count sits at the terminal value for the current direction. That value is all ones when counting up and zero when counting down. The carry ignores the parallel enable. Feeding the carry of one stage into the trickle enable of the next builds a wider synchronous counter with no extra gating.

An optional synchronous clear, provided for initialisation, forces the count to zero. It wins over load.

Top module: `updn_counter`

## Requirements
- R1: When syncClr is high at a rising edge, the count becomes 0 on that edge, whatever the other control inputs are.
- R2: When syncClr is low and loadN is low at a rising edge, the count takes the value of dataIn on that edge, whatever the enables and the direction are.
- R3: When syncClr is low, loadN is high, and both enPN and enTN are low at a rising edge, the count changes by one on that edge. It increases when upDn is 1 and decreases when upDn is 0.
- R4: The count wraps modulo 2^WIDTH. Counting up from all ones gives 0, and counting down from 0 gives all ones.
- R5: When syncClr is low, loadN is high, and either enPN or enTN is high at a rising edge, the count keeps its value.
- R6: rcoN is 0 exactly when enTN is 0 and the count equals its terminal value: all ones if upDn is 1, or 0 if upDn is 0. In every other case rcoN is 1. enPN has no effect on rcoN.
- R7: rcoN is combinational. It follows changes on enTN and upDn within the same cycle, with no clock edge needed.
- R8: The count changes only on a rising clock edge. Changes on the control inputs between edges leave it unchanged.
- R9: Two stages, with the carry of the low stage driving enTN of the high stage and a shared enPN, form a synchronous counter of twice the width. The pair counts up and down through the full range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| syncClr | input | 1 | Synchronous clear to zero, active high |
| loadN | input | 1 | Synchronous parallel load, active low |
| enPN | input | 1 | Parallel count enable, active low |
| enTN | input | 1 | Trickle count enable, active low, also gates the carry |
| upDn | input | 1 | Direction: 1 counts up, 0 counts down |
| dataIn | input | WIDTH | Preset value |
| countOut | output | WIDTH | Current count |
| rcoN | output | 1 | Terminal-count carry, active low |

## Verification
A wrong next-state selection shows on countOut one edge after the stimulus that triggers it. The error then persists, because the count keeps its value or keeps stepping from the wrong value. A wrong terminal decode or enable gating shows on rcoN within the same cycle, since rcoN is combinational.

The bench sweeps every start value against every control combination and compares the result with arithmetic computed in the bench. It then runs a chained pair through a full cycle in both directions, so that a carry fault appears as a wrong upper count within one edge of the wrap.

// File: rtl/updn_counter_pkg.sv
package updn_counter_pkg;
  typedef struct packed {
    logic clear;
    logic load;
    logic step;
    logic up;
  } ctrlStrobes_t;
endpackage

// File: rtl/updn_counter_ctrl.sv
module updn_counter_ctrl
  import updn_counter_pkg::*;
(
  input  logic         syncClr,
  input  logic         loadN,
  input  logic         enPN,
  input  logic         enTN,
  input  logic         upDn,
  output ctrlStrobes_t strobes
);
  always_comb begin
    strobes.clear = syncClr;
    strobes.load  = !syncClr && !loadN;
    strobes.step  = !syncClr && loadN && !enPN && !enTN;
    strobes.up    = upDn;
  end
endmodule

// File: rtl/updn_counter_dp.sv
module updn_counter_dp
  import updn_counter_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  ctrlStrobes_t     strobes,
  input  logic             enTN,
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH-1:0] count,
  output logic             rcoN
);
  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ONE      = {{(WIDTH-1){1'b0}}, 1'b1};

  logic [WIDTH-1:0] countQ;
  logic [WIDTH-1:0] countNext;
  logic             atTerm;

  always_comb begin
    countNext = countQ;
    if (strobes.clear)      countNext = '0;
    else if (strobes.load)  countNext = dataIn;
    else if (strobes.step)  countNext = strobes.up ? countQ + ONE : countQ - ONE;
  end

  always_ff @(posedge clk) countQ <= countNext;

  assign atTerm = strobes.up ? (countQ == ALL_ONES) : (countQ == '0);
  assign rcoN   = !(atTerm && !enTN);
  assign count  = countQ;
endmodule

// File: rtl/updn_counter.sv
module updn_counter
  import updn_counter_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             syncClr,
  input  logic             loadN,
  input  logic             enPN,
  input  logic             enTN,
  input  logic             upDn,
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH-1:0] countOut,
  output logic             rcoN
);
  ctrlStrobes_t strobes;

  updn_counter_ctrl u_ctrl (
    .syncClr(syncClr), .loadN(loadN), .enPN(enPN), .enTN(enTN),
    .upDn(upDn), .strobes(strobes)
  );

  updn_counter_dp #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .strobes(strobes), .enTN(enTN), .dataIn(dataIn),
    .count(countOut), .rcoN(rcoN)
  );
endmodule

// File: rtl/updn_counter_chk.sv
module updn_counter_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             syncClr,
  input logic             loadN,
  input logic             enPN,
  input logic             enTN,
  input logic             upDn,
  input logic [WIDTH-1:0] dataIn,
  input logic [WIDTH-1:0] countOut,
  input logic             rcoN
);
  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ONE      = {{(WIDTH-1){1'b0}}, 1'b1};

  logic started = 1'b0;
  always_ff @(posedge clk) if (syncClr) started <= 1'b1;

  assert_clear_R1: assert property (@(posedge clk)
    syncClr |=> countOut == '0);

  assert_load_R2: assert property (@(posedge clk) disable iff (!started)
    (!syncClr && !loadN) |=> countOut == $past(dataIn));

  assert_step_R3: assert property (@(posedge clk) disable iff (!started || syncClr)
    (!syncClr && loadN && !enPN && !enTN) |=>
      countOut == ($past(upDn) ? $past(countOut) + ONE : $past(countOut) - ONE));

  assert_wrap_R4: assert property (@(posedge clk) disable iff (!started || syncClr)
    (loadN && !enPN && !enTN && upDn && countOut == ALL_ONES) |=> countOut == '0);

  assert_hold_R5: assert property (@(posedge clk) disable iff (!started || syncClr)
    (loadN && (enPN || enTN)) |=> $stable(countOut));

  always_comb begin
    if (started)
      assert_carry_R6: assert (rcoN == !(!enTN &&
        (upDn ? countOut == ALL_ONES : countOut == '0)));
  end
endmodule

bind updn_counter updn_counter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .syncClr(syncClr), .loadN(loadN), .enPN(enPN), .enTN(enTN),
  .upDn(upDn), .dataIn(dataIn), .countOut(countOut), .rcoN(rcoN)
);

// File: tb/sim_updn_counter.sv
`timescale 1ns/1ps
module sim_updn_counter;
  localparam int W = 4;
  localparam int M = 1 << W;

  logic clk = 0;
  always #5 clk = ~clk;

  logic syncClr, loadN, enPN, enTN, upDn;
  logic [W-1:0] dataIn, countOut;
  logic rcoN;

  updn_counter #(.WIDTH(W)) u0 (
    .clk(clk), .syncClr(syncClr), .loadN(loadN), .enPN(enPN), .enTN(enTN),
    .upDn(upDn), .dataIn(dataIn), .countOut(countOut), .rcoN(rcoN)
  );

  logic cClr, cLoadN, cEnPN, cUp;
  logic [W-1:0] cLoData, cHiData, cLo, cHi;
  logic cRcoLo, cRcoHi;
  updn_counter #(.WIDTH(W)) u_lo (
    .clk(clk), .syncClr(cClr), .loadN(cLoadN), .enPN(cEnPN), .enTN(1'b0),
    .upDn(cUp), .dataIn(cLoData), .countOut(cLo), .rcoN(cRcoLo)
  );
  updn_counter #(.WIDTH(W)) u_hi (
    .clk(clk), .syncClr(cClr), .loadN(cLoadN), .enPN(cEnPN), .enTN(cRcoLo),
    .upDn(cUp), .dataIn(cHiData), .countOut(cHi), .rcoN(cRcoHi)
  );

  int nChecks = 0, nFails = 0;
  bit done = 0;

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expRco(input int cnt, input logic t, input logic up);
    return (!t && (up ? cnt == M-1 : cnt == 0)) ? 0 : 1;
  endfunction

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic setCount(input int v);
    syncClr = 0; loadN = 0; dataIn = W'(v); tick(); loadN = 1;
  endtask

  initial begin
    #1500000;
    nFails++; nChecks++;
    $display("FAIL watchdog actual=0 expected=1");
    done = 1;
  end

  initial begin
    syncClr = 1; loadN = 0; enPN = 0; enTN = 0; upDn = 1; dataIn = 4'd9;
    cClr = 1; cLoadN = 1; cEnPN = 1; cUp = 1; cLoData = 0; cHiData = 0;
    #1; tick();
    check("R1 clear over load", countOut, 0);
    syncClr = 0; cClr = 0;

    // R2 load over every enable/direction, R3/R4/R5 over every start value
    for (int v = 0; v < M; v++) begin
      for (int c = 0; c < 8; c++) begin
        setCount(v);
        check("R2 load", countOut, v);
        enPN = c[0]; enTN = c[1]; upDn = c[2];
        #1;
        check("R6 carry", rcoN, expRco(v, enTN, upDn));
        enPN = ~enPN; #1;
        check("R6 enP ignored", rcoN, expRco(v, enTN, upDn));
        enPN = ~enPN;
        tick();
        if (!enPN && !enTN)
          check(upDn ? ((v == M-1) ? "R4 wrap up" : "R3 up")
                     : ((v == 0) ? "R4 wrap down" : "R3 down"),
                countOut, upDn ? (v+1)%M : (v+M-1)%M);
        else
          check("R5 hold", countOut, v);
      end
    end

    // R2 load ignores enables
    enPN = 0; enTN = 0; upDn = 1; setCount(5); dataIn = 4'd12; loadN = 0; tick();
    check("R2 load beats count", countOut, 12);
    loadN = 1;

    // R7 combinational response to upDn and enTN
    setCount(0); enTN = 1; enPN = 1; upDn = 1; #1;
    check("R7 idle", rcoN, 1);
    upDn = 0; #1; check("R7 upDn response", rcoN, 1);
    enTN = 0; #1; check("R7 enTN response", rcoN, 0);
    upDn = 1; #1; check("R7 direction swap", rcoN, 1);

    // R8 mid-cycle control changes do not alter count
    enPN = 1; enTN = 1; setCount(7);
    @(negedge clk);
    loadN = 0; dataIn = 4'd2; enPN = 0; enTN = 0; #1;
    check("R8 no change before edge", countOut, 7);
    loadN = 1; enPN = 1; enTN = 1; tick();
    check("R8 hold after glitch", countOut, 7);

    // R9 cascade: count up through all 256 then down
    cClr = 1; tick(); cClr = 0; cEnPN = 0; cUp = 1;
    for (int i = 1; i <= M*M; i++) begin
      tick();
      check("R9 cascade up", {cHi, cLo}, i % (M*M));
    end
    cUp = 0;
    for (int i = 1; i <= M*M; i++) begin
      tick();
      check("R9 cascade down", {cHi, cLo}, (M*M - i) % (M*M));
    end
    cEnPN = 1; tick();
    check("R9 cascade hold", {cHi, cLo}, 0);
    done = 1;
  end

  initial begin
    wait (done);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule